// File: doc/BRIEF.md
# Time-Slotted Serial Receiver

This block receives a time-division multiplexed serial stream. A frame starts with a frame-sync pulse. It is followed by a programmable number of back-to-back slots, each carrying one word. The clock-recovery logic of the port delivers a one-cycle `bit_stb` strobe for every serial bit clock. On each strobe the block samples `fsync` and `sdata`. The bit that is sampled together with `fsync` is the first bit of slot 0.

Each completed word moves from the shift register into a holding register. The move raises a data-ready flag, plus an interrupt when the interrupt enable is set. The host empties the holding register with a data read strobe. A word that completes while the previous one is still unread is dropped and flagged as an overrun. The receive enable is honoured only at frame boundaries: after it is turned off, the receiver completes the slot in progress and stays idle until the next frame sync. A status bit tells software whether the held word came from slot 0, so that it can steer words into per-channel buffers.

Top module: `tdm_rx`

## Requirements
- R1: After reset, `rx_word` is zero and `rdf`, `roe`, `first_slot` and `irq` are all low.
- R2: A `bit_stb` with `fsync` high while `rx_en` is high starts a frame. The bit sampled on that strobe is bit 0 of slot 0.
- R3: If `rx_en` is low at the frame-sync strobe, no slot of that frame is captured, even when `rx_en` rises later in the frame.
- R4: On the strobe that completes a word, `rx_word` takes the word, right-justified with the upper bits zero, and `rdf` rises in the next cycle. `irq` equals `rdf` AND `rie`.
- R5: The slots of a frame follow one another with no gap. A frame holds `slots_m1`+1 slots, and bits after the last slot are ignored until the next frame sync.
- R6: A `rd_data_stb` pulse clears `rdf`, unless a new word is loaded in the same cycle.
- R7: A word that completes while `rdf` is high and no data read is under way sets `roe` and is discarded. `rx_word` and `first_slot` keep their old values.
- R8: `roe` is sticky. It is cleared only by a `rd_stat_stb` pulse while `roe` is set, followed later by a `rd_data_stb` pulse. A data read alone leaves it set.
- R9: If `rx_en` goes low at any time during a frame, even if it returns high at once, the slot in progress is completed and captured. The remaining slots of that frame are ignored.
- R10: `first_slot` is 1 when the held word came from slot 0 and 0 for any other slot.
- R11: `wl_sel` picks the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24.
- R12: With `lsb_first` low, the first bit received is the word's MSB. With `lsb_first` high, the first bit received is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per serial bit clock |
| fsync | input | 1 | Frame sync, sampled on `bit_stb` |
| sdata | input | 1 | Serial data, sampled on `bit_stb` |
| rx_en | input | 1 | Receive enable, qualified at frame boundaries |
| rie | input | 1 | Receive interrupt enable |
| lsb_first | input | 1 | 1 = LSB-first shifting |
| wl_sel | input | 2 | Word length code: 0 = 8, 1 = 12, 2 = 16, 3 = 24 bits |
| slots_m1 | input | SLOT_W | Slots per frame minus one |
| rd_data_stb | input | 1 | Host read of the holding register |
| rd_stat_stb | input | 1 | Host read of the status |
| rx_word | output | 24 | Holding register, right-justified |
| rdf | output | 1 | Receive data full |
| roe | output | 1 | Sticky receive overrun |
| first_slot | output | 1 | Held word came from slot 0 |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest cases to reach are the ones tied to timing within a frame. One is an enable pulse that drops and recovers inside a single slot, which must still end the frame after that slot. Another is an enable that rises just after the frame sync. The bench reaches both by placing the `rx_en` change on a chosen bit of a word as it is serialised. It then sends the later slots and checks that neither `rdf` nor `roe` moves, since an overrun would reveal a slot that was wrongly captured. A behavioural model runs alongside and checks every output on every clock.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int DATA_W = 24;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_12 = 2'd1,
        WL_16 = 2'd2,
        WL_24 = 2'd3
    } wl_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              slot0;
    } held_t;

    function automatic logic [IDX_W-1:0] wl_bits(input logic [1:0] code);
        case (wl_e'(code))
            WL_8:    return IDX_W'(8);
            WL_12:   return IDX_W'(12);
            WL_16:   return IDX_W'(16);
            default: return IDX_W'(24);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] shift_in(
        input logic [DATA_W-1:0] cur,
        input logic              b,
        input logic [IDX_W-1:0]  idx,
        input logic              restart,
        input logic              lsb
    );
        logic [DATA_W-1:0] base;
        base = restart ? '0 : cur;
        if (lsb)
            return base | (DATA_W'(b) << idx);
        else
            return {base[DATA_W-2:0], b};
    endfunction

endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              fsync,
    input  logic              rx_en,
    input  logic [1:0]        wl_sel,
    input  logic [SLOT_W-1:0] slots_m1,
    output logic              take_bit,
    output logic              first_bit,
    output logic              word_done,
    output logic              in_slot0,
    output logic [IDX_W-1:0]  bit_idx
);

    logic              frame_on;
    logic              en_drop;
    logic [IDX_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              frame_start;
    logic              last_bit;
    logic              last_slot;

    assign frame_start = bit_stb & fsync;
    assign last_bit    = (bit_q == wl_bits(wl_sel) - IDX_W'(1));
    assign last_slot   = (slot_q == slots_m1);

    assign take_bit  = (frame_start & rx_en) | (bit_stb & ~fsync & frame_on);
    assign first_bit = take_bit & (fsync | (bit_q == '0));
    assign word_done = bit_stb & ~fsync & frame_on & last_bit;
    assign in_slot0  = (slot_q == '0);
    assign bit_idx   = fsync ? '0 : bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_on <= 1'b0;
            en_drop  <= 1'b0;
            bit_q    <= '0;
            slot_q   <= '0;
        end else if (frame_start) begin
            frame_on <= rx_en;
            en_drop  <= 1'b0;
            bit_q    <= IDX_W'(1);
            slot_q   <= '0;
        end else begin
            if (!rx_en)
                en_drop <= 1'b1;
            if (bit_stb && frame_on) begin
                if (last_bit) begin
                    bit_q <= '0;
                    if (last_slot || en_drop || !rx_en)
                        frame_on <= 1'b0;
                    else
                        slot_q <= slot_q + SLOT_W'(1);
                end else begin
                    bit_q <= bit_q + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift
    import tdm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_bit,
    input  logic              first_bit,
    input  logic              sdata,
    input  logic              lsb_first,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] word_next
);

    logic [DATA_W-1:0] sh_q;

    assign word_next = shift_in(sh_q, sdata, bit_idx, first_bit, lsb_first);

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (take_bit)
            sh_q <= word_next;
    end

endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold
    import tdm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_next,
    input  logic              in_slot0,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [DATA_W-1:0] rx_word,
    output logic              rdf,
    output logic              roe,
    output logic              first_slot
);

    held_t held_q;
    logic  rdf_q;
    logic  roe_q;
    logic  stat_seen;
    logic  overrun;

    assign overrun = word_done & rdf_q & ~rd_data_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q    <= '0;
            rdf_q     <= 1'b0;
            roe_q     <= 1'b0;
            stat_seen <= 1'b0;
        end else begin
            if (word_done && !overrun) begin
                held_q <= '{data: word_next, slot0: in_slot0};
                rdf_q  <= 1'b1;
            end else if (rd_data_stb) begin
                rdf_q <= 1'b0;
            end

            if (overrun) begin
                roe_q <= 1'b1;
            end else if (rd_data_stb && stat_seen) begin
                roe_q <= 1'b0;
            end

            if (rd_stat_stb && roe_q)
                stat_seen <= 1'b1;
            else if (rd_data_stb)
                stat_seen <= 1'b0;
        end
    end

    assign rx_word    = held_q.data;
    assign first_slot = held_q.slot0;
    assign rdf        = rdf_q;
    assign roe        = roe_q;

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              rx_en,
    input  logic              rie,
    input  logic              lsb_first,
    input  logic [1:0]        wl_sel,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [23:0]       rx_word,
    output logic              rdf,
    output logic              roe,
    output logic              first_slot,
    output logic              irq
);

    logic              take_bit;
    logic              first_bit;
    logic              word_done;
    logic              in_slot0;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] word_next;

    tdm_rx_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .fsync     (fsync),
        .rx_en     (rx_en),
        .wl_sel    (wl_sel),
        .slots_m1  (slots_m1),
        .take_bit  (take_bit),
        .first_bit (first_bit),
        .word_done (word_done),
        .in_slot0  (in_slot0),
        .bit_idx   (bit_idx)
    );

    tdm_rx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .take_bit  (take_bit),
        .first_bit (first_bit),
        .sdata     (sdata),
        .lsb_first (lsb_first),
        .bit_idx   (bit_idx),
        .word_next (word_next)
    );

    tdm_rx_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .word_done   (word_done),
        .word_next   (word_next),
        .in_slot0    (in_slot0),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .rx_word     (rx_word),
        .rdf         (rdf),
        .roe         (roe),
        .first_slot  (first_slot)
    );

    assign irq = rdf & rie;

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_data_stb,
    input logic        word_done,
    input logic        rdf,
    input logic        roe,
    input logic [23:0] rx_word
);

    // R6
    rdf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_stb && !word_done |=> !rdf);

    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rdf && word_done && !rd_data_stb |=> $stable(rx_word) && roe);

    // R8
    roe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        roe && !rd_data_stb |=> roe);

    // R4
    rdf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdf) |-> $past(word_done));

    // R4
    word_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> $past(word_done));

endmodule

bind tdm_rx tdm_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_data_stb (rd_data_stb),
    .word_done   (word_done),
    .rdf         (rdf),
    .roe         (roe),
    .rx_word     (rx_word)
);

// File: tb/tb_tdm_rx.sv
module tb_tdm_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_stb = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic        rx_en = 1'b0;
    logic        rie = 1'b0;
    logic        lsb_first = 1'b0;
    logic [1:0]  wl_sel = 2'd2;
    logic [4:0]  slots_m1 = 5'd1;
    logic        rd_data_stb = 1'b0;
    logic        rd_stat_stb = 1'b0;
    logic [23:0] rx_word;
    logic        rdf, roe, first_slot, irq;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    tdm_rx dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .fsync(fsync), .sdata(sdata),
        .rx_en(rx_en), .rie(rie), .lsb_first(lsb_first), .wl_sel(wl_sel),
        .slots_m1(slots_m1), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
        .rx_word(rx_word), .rdf(rdf), .roe(roe), .first_slot(first_slot), .irq(irq)
    );

    // Behavioural reference model
    logic [23:0] m_acc, m_hold, m_word;
    int          m_pos, m_slot;
    bit          m_live, m_drop, m_rdf, m_roe, m_seen, m_first, m_wfirst;

    function automatic int wl_of(input logic [1:0] c);
        case (c)
            2'd0: return 8;
            2'd1: return 12;
            2'd2: return 16;
            default: return 24;
        endcase
    endfunction

    always @(posedge clk) begin
        bit done, ovr, old_roe, old_seen;
        done = 0;
        if (rst) begin
            m_acc = 0; m_hold = 0; m_pos = 0; m_slot = 0;
            m_live = 0; m_drop = 0; m_rdf = 0; m_roe = 0; m_seen = 0; m_first = 0;
        end else begin
            if (bit_stb && fsync) begin
                m_live = rx_en; m_slot = 0; m_pos = 0; m_drop = 0; m_acc = 0;
                if (rx_en) begin
                    m_acc = lsb_first ? 24'(sdata) : {23'd0, sdata};
                    m_pos = 1;
                end
            end else begin
                if (bit_stb && m_live) begin
                    if (lsb_first) m_acc = m_acc | (24'(sdata) << m_pos);
                    else           m_acc = (m_acc << 1) | 24'(sdata);
                    m_pos++;
                    if (m_pos == wl_of(wl_sel)) begin
                        done = 1; m_word = m_acc; m_wfirst = (m_slot == 0);
                        m_pos = 0; m_acc = 0;
                        if (m_slot == int'(slots_m1) || m_drop || !rx_en) m_live = 0;
                        else m_slot++;
                    end
                end
                if (!rx_en) m_drop = 1;
            end
            old_roe = m_roe; old_seen = m_seen;
            ovr = done && m_rdf && !rd_data_stb;
            if (done && !ovr) begin
                m_hold = m_word; m_rdf = 1; m_first = m_wfirst;
            end else if (rd_data_stb) begin
                m_rdf = 0;
            end
            if (ovr) m_roe = 1;
            else if (rd_data_stb && old_seen) m_roe = 0;
            if (rd_stat_stb && old_roe) m_seen = 1;
            else if (rd_data_stb) m_seen = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (rx_word !== m_hold || rdf !== m_rdf || roe !== m_roe ||
                first_slot !== m_first || irq !== (m_rdf & rie)) begin
                errors++;
                $display("FAIL model R2/R4/R5/R9 at %0t: got word=%h rdf=%b roe=%b first=%b irq=%b exp word=%h rdf=%b roe=%b first=%b irq=%b",
                         $time, rx_word, rdf, roe, first_slot, irq,
                         m_hold, m_rdf, m_roe, m_first, m_rdf & rie);
            end
        end
    end

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic fs);
        bit_stb = 1'b1; fsync = fs; sdata = b;
        @(negedge clk);
        bit_stb = 1'b0; fsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] v, input bit fs, input int drop_at, input int raise_at);
        int n = wl_of(wl_sel);
        for (int i = 0; i < n; i++) begin
            send_bit(lsb_first ? v[i] : v[n-1-i], fs && (i == 0));
            if (i == raise_at) rx_en = 1'b1;
            if (i == drop_at) begin
                rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
            end
        end
    endtask

    task automatic rd_data();
        rd_data_stb = 1'b1; @(negedge clk); rd_data_stb = 1'b0; @(negedge clk);
    endtask

    task automatic rd_stat();
        rd_stat_stb = 1'b1; @(negedge clk); rd_stat_stb = 1'b0; @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 word", rx_word, 24'h0);
        chk("R1 flags", {20'd0, rdf, roe, first_slot, irq}, 24'h0);

        // R2 R4 R10: 16-bit, two slots, interrupts on
        rx_en = 1; rie = 1; wl_sel = 2'd2; slots_m1 = 5'd1;
        send_word(24'h00A5C3, 1, -1, -1);
        chk("R2 R4 word", rx_word, 24'h00A5C3);
        chk("R4 rdf irq", {22'd0, rdf, irq}, 24'h3);
        chk("R10 first", {23'd0, first_slot}, 24'h1);
        rd_data();
        chk("R6 rdf cleared", {23'd0, rdf}, 24'h0);
        send_word(24'h003C0F, 0, -1, -1);
        chk("R5 second slot", rx_word, 24'h003C0F);
        chk("R10 not first", {23'd0, first_slot}, 24'h0);
        rd_data();
        send_word(24'h00FFFF, 0, -1, -1);
        chk("R5 beyond last slot", {22'd0, rdf, roe}, 24'h0);
        chk("R5 word kept", rx_word, 24'h003C0F);

        // R7 R8 overrun
        rie = 0;
        send_word(24'h001111, 1, -1, -1);
        send_word(24'h002222, 0, -1, -1);
        chk("R7 old word kept", rx_word, 24'h001111);
        chk("R7 roe set", {22'd0, rdf, roe}, 24'h3);
        chk("R4 irq masked", {23'd0, irq}, 24'h0);
        rd_data();
        chk("R8 data read alone", {22'd0, rdf, roe}, 24'h1);
        rd_stat();
        rd_data();
        chk("R8 cleared", {23'd0, roe}, 24'h0);

        // R3 enable raised after frame sync
        rx_en = 0;
        send_word(24'h00ABCD, 1, -1, 0);
        send_word(24'h001234, 0, -1, -1);
        chk("R3 nothing captured", {22'd0, rdf, roe}, 24'h0);
        send_word(24'h004321, 1, -1, -1);
        chk("R3 next frame", rx_word, 24'h004321);
        rd_data();

        // R9 enable pulsed low inside slot 0 of a four-slot frame
        wl_sel = 2'd0; slots_m1 = 5'd3;
        send_word(24'h00005A, 1, 3, -1);
        send_word(24'h0000C3, 0, -1, -1);
        send_word(24'h0000E7, 0, -1, -1);
        chk("R9 slot finished", rx_word, 24'h00005A);
        chk("R9 rest ignored", {22'd0, rdf, roe}, 24'h2);
        rd_data();

        // R11 word lengths, R12 bit order
        slots_m1 = 5'd0;
        send_word(24'h000096, 1, -1, -1);
        chk("R11 8-bit", rx_word, 24'h000096);
        rd_data();
        wl_sel = 2'd1;
        send_word(24'h000B4E, 1, -1, -1);
        chk("R11 12-bit", rx_word, 24'h000B4E);
        rd_data();
        wl_sel = 2'd3;
        send_word(24'hC0FFEE, 1, -1, -1);
        chk("R11 24-bit", rx_word, 24'hC0FFEE);
        rd_data();
        wl_sel = 2'd2; lsb_first = 1;
        send_word(24'h001234, 1, -1, -1);
        chk("R12 lsb first", rx_word, 24'h001234);
        rd_data();

        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule